// File: doc/BRIEF.md
# Banked Serial-Port Register Interface

This block is the processor-facing register file of a PC-style serial controller. A host uses a 3-bit offset, an 8-bit data bus and separate read and write strobes to reach eight byte-wide locations. Bit 7 of the line-control register is the bank-select bit. When it is set, offsets 0 and 1 hold the two bytes of a 16-bit baud divisor. When it is clear, the same offsets are the data port and the interrupt-enable register. Offset 2 reads as the interrupt-identification register, and writes to it are dropped.

Outgoing bytes go to an external transmit shifter through a valid/ready pair. Incoming bytes arrive from an external receive shifter as a one-cycle valid pulse. Line-error and modem-change events arrive as single-cycle pulses. The block drives a 16x baud tick derived from the divisor, an interrupt line, and the seven line-format control bits. The usual bring-up order is: clear the enables, set the bank bit, write the divisor high byte and then the low byte, and clear the bank bit.

Top module: `uart_regbank`

## Requirements
- R1: After reset the line-control, enable and divisor registers are 0, `baudTick` stays low, `txValid` and `irq` are low, the status register (offset 5) reads 0x60 and offset 2 reads 0x01.
- R2: With the bank bit (line-control bit 7) set, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8. With the bank bit clear, offset 0 is the data port and offset 1 is the enable register.
- R3: With the bank bit clear, a write to offset 0 presents the byte on `txData` and raises `txValid`. A cycle with `txValid` and `txReady` both high drops `txValid`. Transmit and receive bytes are held in separate registers.
- R4: A `rxValid` pulse stores `rxData` and sets status bit 0. Reading offset 0 with the bank bit clear returns the byte and clears bit 0. A byte that arrives while bit 0 is already set sets status bit 1 (overrun).
- R5: Enable bits 3:0 (0 received data, 1 transmit empty, 2 line status, 3 modem change) can be written and read back. Bits 7:4 read as 0. A cleared enable bit keeps its source out of `irq` and out of offset 2.
- R6: Offset 2 reads {5'b0, id[1:0], nPending}. nPending is 1 when no enabled source is active. The ids in priority order are: line status 2'b11, received data 2'b10, transmit empty 2'b01, modem change 2'b00. `irq` is high exactly when nPending is 0.
- R7: The transmit-empty source is set when a byte is handed to the shifter. It is cleared by a read of offset 2 that reports it, or by a new write to offset 0.
- R8: Offset 3 holds all 8 line-control bits with full read-back. `lineCtrl` outputs bits 6:0: word length 1:0, stop bits 2, parity enable 3, even parity 4, stick parity 5, break 6.
- R9: Offset 7 is a read/write scratch byte. Writes to offsets 2, 4 and 6 change no state. Offsets 4 and 6 read as 0.
- R10: With divisor N > 0, `baudTick` pulses once every N clocks. A write to either divisor byte restarts the count, so the first tick comes in the Nth cycle after the write edge. A divisor of 0 stops the tick.
- R11: Status bit 2 latches a `lineErr` pulse. A read of offset 5 clears status bits 1 and 2. A `modemChg` pulse raises the modem-change source, and a read of offset 6 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (read side effects occur at the edge) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr`, combinational |
| txData | output | 8 | Byte offered to the transmit shifter |
| txValid | output | 1 | Transmit byte pending |
| txReady | input | 1 | Shifter accepts the byte |
| rxData | input | 8 | Byte from the receive shifter |
| rxValid | input | 1 | One-cycle receive pulse |
| lineErr | input | 1 | One-cycle receive line error pulse |
| modemChg | input | 1 | One-cycle modem status change pulse |
| lineCtrl | output | 7 | Line format bits 6:0 |
| baudTick | output | 1 | 16x baud tick |
| irq | output | 1 | Interrupt request |

## Verification
A wrong bank bit or wrong offset decode shows up on the next read as a divisor byte in place of data, or the reverse. A lost or stuck flag shows up on the very next status or identification read and on `irq` in the same cycle. The bench therefore reads both offsets after every event that should set or clear a source. A wrong baud counter reload moves the first tick after a divisor write, and a wrong terminal count changes the spacing. Both are visible within one divisor period, so the bench checks every cycle over several periods.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
  localparam logic [2:0] OFS_DATA  = 3'd0;
  localparam logic [2:0] OFS_IER   = 3'd1;
  localparam logic [2:0] OFS_IIR   = 3'd2;
  localparam logic [2:0] OFS_LCR   = 3'd3;
  localparam logic [2:0] OFS_MCTL  = 3'd4;
  localparam logic [2:0] OFS_LSR   = 3'd5;
  localparam logic [2:0] OFS_MSTAT = 3'd6;
  localparam logic [2:0] OFS_SCR   = 3'd7;

  localparam logic [1:0] ID_LINE  = 2'b11;
  localparam logic [1:0] ID_RX    = 2'b10;
  localparam logic [1:0] ID_TX    = 2'b01;
  localparam logic [1:0] ID_MODEM = 2'b00;

  typedef struct packed {
    logic wrThr;
    logic wrIer;
    logic wrLcr;
    logic wrDivLo;
    logic wrDivHi;
    logic wrScr;
    logic rdRbr;
    logic rdLsr;
    logic rdMstat;
    logic clrThre;
  } regStrobe_t;
endpackage

// File: rtl/uart_regbank_baud.sv
module uart_regbank_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic             reload,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);
  localparam logic [DIV_W-1:0] ZERO = '0;

  logic [DIV_W-1:0] cnt;
  logic             lastCnt;

  assign lastCnt = (divisor != ZERO) && (cnt == divisor - ONE);
  assign tick    = lastCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= ZERO;
    end else if (reload || divisor == ZERO || lastCnt) begin
      cnt <= ZERO;
    end else begin
      cnt <= cnt + ONE;
    end
  end

  AST_TICK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (divisor == ZERO) |-> !tick); // R10
  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (tick && divisor > ONE && !reload) |=> !tick); // R10
endmodule

// File: rtl/uart_regbank_ctrl.sv
module uart_regbank_ctrl
  import uart_regbank_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              dlab,
  input  logic [3:0]        ierBits,
  input  logic              srcLine,
  input  logic              srcRx,
  input  logic              srcTx,
  input  logic              srcModem,
  output regStrobe_t        strobes,
  output logic [7:0]        iirVal,
  output logic              irq
);
  logic       actLine, actRx, actTx, actModem, anyAct;
  logic [1:0] idSel;

  assign actRx    = srcRx    & ierBits[0];
  assign actTx    = srcTx    & ierBits[1];
  assign actLine  = srcLine  & ierBits[2];
  assign actModem = srcModem & ierBits[3];
  assign anyAct   = actLine | actRx | actTx | actModem;

  always_comb begin
    if (actLine)      idSel = ID_LINE;
    else if (actRx)   idSel = ID_RX;
    else if (actTx)   idSel = ID_TX;
    else              idSel = ID_MODEM;
  end

  assign iirVal = {5'b0, idSel, ~anyAct};
  assign irq    = anyAct;

  always_comb begin
    strobes         = '0;
    strobes.wrThr   = wrEn && addr == OFS_DATA && !dlab;
    strobes.wrDivLo = wrEn && addr == OFS_DATA && dlab;
    strobes.wrIer   = wrEn && addr == OFS_IER  && !dlab;
    strobes.wrDivHi = wrEn && addr == OFS_IER  && dlab;
    strobes.wrLcr   = wrEn && addr == OFS_LCR;
    strobes.wrScr   = wrEn && addr == OFS_SCR;
    strobes.rdRbr   = rdEn && addr == OFS_DATA && !dlab;
    strobes.rdLsr   = rdEn && addr == OFS_LSR;
    strobes.rdMstat = rdEn && addr == OFS_MSTAT;
    strobes.clrThre = rdEn && addr == OFS_IIR && anyAct && idSel == ID_TX;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrThr, strobes.wrDivLo, strobes.wrIer, strobes.wrDivHi,
              strobes.wrLcr, strobes.wrScr})); // R2
endmodule

// File: rtl/uart_regbank_dp.sv
module uart_regbank_dp
  import uart_regbank_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  input  regStrobe_t        strobes,
  input  logic [7:0]        iirVal,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] txData,
  output logic              txValid,
  input  logic              txReady,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxValid,
  input  logic              lineErr,
  input  logic              modemChg,
  output logic              dlab,
  output logic [3:0]        ierBits,
  output logic [6:0]        lineCtrl,
  output logic [DIV_W-1:0]  divisor,
  output logic              srcLine,
  output logic              srcRx,
  output logic              srcTx,
  output logic              srcModem
);
  localparam int HALF = DIV_W / 2;

  logic [7:0]        lcrQ;
  logic [3:0]        ierQ;
  logic [DIV_W-1:0]  divQ;
  logic [DATA_W-1:0] scrQ, thrQ, rbrQ;
  logic              thrFull, threPend, dataReady, overrunQ, lineErrQ, modemQ;
  logic [7:0]        lsrVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lcrQ <= '0; ierQ <= '0; divQ <= '0; scrQ <= '0; thrQ <= '0; rbrQ <= '0;
      thrFull <= 1'b0; threPend <= 1'b0; dataReady <= 1'b0;
      overrunQ <= 1'b0; lineErrQ <= 1'b0; modemQ <= 1'b0;
    end else begin
      if (strobes.wrLcr)   lcrQ <= wrData[7:0];
      if (strobes.wrIer)   ierQ <= wrData[3:0];
      if (strobes.wrScr)   scrQ <= wrData;
      if (strobes.wrDivLo) divQ[HALF-1:0] <= wrData[HALF-1:0];
      if (strobes.wrDivHi) divQ[DIV_W-1:HALF] <= wrData[HALF-1:0];

      if (txValid && txReady) begin
        thrFull  <= 1'b0;
        threPend <= 1'b1;
      end
      if (strobes.clrThre) threPend <= 1'b0;
      if (strobes.wrThr) begin
        thrQ     <= wrData;
        thrFull  <= 1'b1;
        threPend <= 1'b0;
      end

      if (strobes.rdLsr) begin
        overrunQ <= 1'b0;
        lineErrQ <= 1'b0;
      end
      if (lineErr) lineErrQ <= 1'b1;

      if (strobes.rdRbr) dataReady <= 1'b0;
      if (rxValid) begin
        rbrQ      <= rxData;
        dataReady <= 1'b1;
        if (dataReady && !strobes.rdRbr) overrunQ <= 1'b1;
      end

      if (strobes.rdMstat) modemQ <= 1'b0;
      if (modemChg)        modemQ <= 1'b1;
    end
  end

  assign txData   = thrQ;
  assign txValid  = thrFull;
  assign dlab     = lcrQ[7];
  assign ierBits  = ierQ;
  assign lineCtrl = lcrQ[6:0];
  assign divisor  = divQ;
  assign srcLine  = overrunQ | lineErrQ;
  assign srcRx    = dataReady;
  assign srcTx    = threPend;
  assign srcModem = modemQ;
  assign lsrVal   = {1'b0, ~thrFull, ~thrFull, 2'b00, lineErrQ, overrunQ, dataReady};

  always_comb begin
    case (addr)
      OFS_DATA: rdData = dlab ? DATA_W'(divQ[HALF-1:0])     : rbrQ;
      OFS_IER:  rdData = dlab ? DATA_W'(divQ[DIV_W-1:HALF]) : DATA_W'(ierQ);
      OFS_IIR:  rdData = DATA_W'(iirVal);
      OFS_LCR:  rdData = DATA_W'(lcrQ);
      OFS_LSR:  rdData = DATA_W'(lsrVal);
      OFS_SCR:  rdData = scrQ;
      default:  rdData = '0;
    endcase
  end

  AST_RBR_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdRbr && !rxValid) |=> !srcRx); // R4
  AST_THR_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady && !strobes.wrThr) |=> !txValid); // R3
  AST_IER_RSVD: assert property (@(posedge clk) disable iff (!rstN)
    (addr == OFS_IER && !dlab) |-> rdData[7:4] == 4'b0); // R5
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] txData,
  output logic              txValid,
  input  logic              txReady,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxValid,
  input  logic              lineErr,
  input  logic              modemChg,
  output logic [6:0]        lineCtrl,
  output logic              baudTick,
  output logic              irq
);
  localparam int DIV_W = 2 * DATA_W;

  regStrobe_t       strobes;
  logic [7:0]       iirVal;
  logic             dlab, srcLine, srcRx, srcTx, srcModem;
  logic [3:0]       ierBits;
  logic [DIV_W-1:0] divisor;

  uart_regbank_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .dlab(dlab), .ierBits(ierBits), .srcLine(srcLine), .srcRx(srcRx),
    .srcTx(srcTx), .srcModem(srcModem), .strobes(strobes),
    .iirVal(iirVal), .irq(irq)
  );

  uart_regbank_dp #(.DATA_W(DATA_W), .DIV_W(DIV_W)) dp_i (
    .clk(clk), .rstN(rstN), .addr(addr[2:0]), .wrData(wrData),
    .strobes(strobes), .iirVal(iirVal), .rdData(rdData), .txData(txData),
    .txValid(txValid), .txReady(txReady), .rxData(rxData), .rxValid(rxValid),
    .lineErr(lineErr), .modemChg(modemChg), .dlab(dlab), .ierBits(ierBits),
    .lineCtrl(lineCtrl), .divisor(divisor), .srcLine(srcLine), .srcRx(srcRx),
    .srcTx(srcTx), .srcModem(srcModem)
  );

  uart_regbank_baud #(.DIV_W(DIV_W)) baud_i (
    .clk(clk), .rstN(rstN), .divisor(divisor),
    .reload(strobes.wrDivLo | strobes.wrDivHi), .tick(baudTick)
  );
endmodule

// File: tb/uart_regbank_tb_top.sv
`timescale 1ns/1ps
module uart_regbank_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] addr = '0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0, rxData = '0;
  logic [7:0] rdData, txData;
  logic       txValid, txReady = 1'b0, rxValid = 1'b0;
  logic       lineErr = 1'b0, modemChg = 1'b0;
  logic [6:0] lineCtrl;
  logic       baudTick, irq;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #2.5 clk = ~clk;

  uart_regbank dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .txData(txData), .txValid(txValid),
    .txReady(txReady), .rxData(rxData), .rxValid(rxValid), .lineErr(lineErr),
    .modemChg(modemChg), .lineCtrl(lineCtrl), .baudTick(baudTick), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares each read against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && rdEn) begin
      if (expQ.size() == 0) begin
        check(1'b0, "scoreboard-empty", rdData, 0);
      end else begin
        automatic logic [7:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(rdData == e, t, rdData, e);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    step();
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    expQ.push_back(e); tagQ.push_back(tag);
    addr = a; rdEn = 1'b1;
    step();
    rdEn = 1'b0;
  endtask

  task automatic rxPulse(input logic [7:0] d);
    rxData = d; rxValid = 1'b1;
    step();
    rxValid = 1'b0;
  endtask

  task automatic handoff();
    txReady = 1'b1;
    step();
    txReady = 1'b0;
  endtask

  task automatic pinCheck(input bit act, input bit exp, input string tag);
    @(negedge clk);
    check(act == exp, tag, act, exp);
    @(posedge clk); #1;
  endtask

  // samples baudTick for 12 cycles starting right after a divisor write
  task automatic tickRun(input int n, input string tag);
    for (int i = 0; i < 12; i++) begin
      automatic bit e = (n != 0) && ((i % n) == n - 1);
      @(negedge clk);
      check(baudTick == e, tag, baudTick, e);
      @(posedge clk); #1;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    rd(3'd5, 8'h60, "R1 status");
    rd(3'd2, 8'h01, "R1 ident");
    rd(3'd3, 8'h00, "R1 linectl");
    rd(3'd1, 8'h00, "R1 enable");
    @(negedge clk);
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(txValid == 1'b0, "R1 txValid", txValid, 0);
    @(posedge clk); #1;
    tickRun(0, "R1 R10 no tick at reset");

    // R8 line control
    wr(3'd3, 8'h1B);
    rd(3'd3, 8'h1B, "R8 readback");
    @(negedge clk);
    check(lineCtrl == 7'h1B, "R8 lineCtrl", lineCtrl, 7'h1B);
    @(posedge clk); #1;

    // R2 banking and R10 tick period
    wr(3'd3, 8'h9B);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h04);
    tickRun(4, "R10 period 4");
    rd(3'd0, 8'h04, "R2 divisor low");
    rd(3'd1, 8'h00, "R2 divisor high");
    wr(3'd1, 8'h12);
    rd(3'd1, 8'h12, "R2 divisor high rw");
    wr(3'd1, 8'h00);
    wr(3'd3, 8'h1B);
    rd(3'd0, 8'h00, "R2 data port when bank clear");
    wr(3'd1, 8'hFF);
    rd(3'd1, 8'h0F, "R5 enable reserved zero");
    rd(3'd2, 8'h01, "R6 nothing pending");

    // R3 transmit path
    wr(3'd0, 8'hA5);
    @(negedge clk);
    check(txValid == 1'b1, "R3 txValid", txValid, 1);
    check(txData == 8'hA5, "R3 txData", txData, 8'hA5);
    @(posedge clk); #1;
    rd(3'd0, 8'h00, "R3 receive byte separate");
    handoff();
    pinCheck(txValid, 1'b0, "R3 txValid dropped");
    pinCheck(irq, 1'b1, "R6 irq on tx empty");
    rd(3'd2, 8'h02, "R6 tx empty id");
    rd(3'd2, 8'h01, "R7 cleared by ident read");

    // R4 receive path
    rxPulse(8'h3C);
    rd(3'd5, 8'h61, "R4 data ready");
    rd(3'd2, 8'h04, "R6 rx id");
    rd(3'd0, 8'h3C, "R4 rx byte");
    rd(3'd5, 8'h60, "R4 ready cleared");

    // R4 overrun, R6 priority, R11 clear on status read
    rxPulse(8'h11);
    rxPulse(8'h22);
    rd(3'd2, 8'h06, "R6 line status first");
    rd(3'd5, 8'h63, "R4 overrun flag");
    rd(3'd2, 8'h04, "R11 overrun cleared");
    rd(3'd0, 8'h22, "R4 newest byte");
    lineErr = 1'b1; step(); lineErr = 1'b0;
    rd(3'd5, 8'h64, "R11 line error latched");
    rd(3'd5, 8'h60, "R11 line error cleared");
    modemChg = 1'b1; step(); modemChg = 1'b0;
    rd(3'd2, 8'h00, "R6 modem id");
    pinCheck(irq, 1'b1, "R6 irq on modem");
    rd(3'd6, 8'h00, "R9 modem status reads 0");
    rd(3'd2, 8'h01, "R11 modem cleared");

    // R7 clear by new transmit write
    wr(3'd0, 8'h55);
    handoff();
    rd(3'd2, 8'h02, "R7 tx empty set");
    wr(3'd0, 8'h66);
    rd(3'd2, 8'h01, "R7 cleared by write");
    handoff();

    // R5 masking
    wr(3'd1, 8'h00);
    rxPulse(8'h77);
    rd(3'd2, 8'h01, "R5 masked rx");
    pinCheck(irq, 1'b0, "R5 irq masked");
    rd(3'd0, 8'h77, "R5 byte still stored");

    // R9 scratch and ignored writes
    wr(3'd7, 8'h5A);
    rd(3'd7, 8'h5A, "R9 scratch");
    wr(3'd2, 8'hFF);
    wr(3'd4, 8'hFF);
    wr(3'd6, 8'hFF);
    rd(3'd2, 8'h01, "R9 fifo-ctl write ignored");
    rd(3'd3, 8'h1B, "R9 linectl untouched");
    rd(3'd1, 8'h00, "R9 enable untouched");
    rd(3'd4, 8'h00, "R9 modem ctl reads 0");
    rd(3'd6, 8'h00, "R9 modem status reads 0 after write");

    // R10 restart and stop
    wr(3'd3, 8'h9B);
    wr(3'd0, 8'h03);
    tickRun(3, "R10 restart period 3");
    wr(3'd0, 8'h00);
    tickRun(0, "R10 divisor zero");

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule